// File: doc/BRIEF.md
# Successive-Approximation Converter Bus Controller

This block is the digital control logic of a 14-bit successive-approximation converter, seen from its parallel host bus. A falling edge on the active-low convert-start input begins a conversion. The active-low busy output is held for a fixed number of clock cycles that stands for the conversion time. The analog part of the conversion is not modelled. At the end of the conversion, the value on the `conv_result` port is taken as the converter's answer and the stored offset is added to it, which gives a 15-bit output word.

Two latching modes decide when that word reaches the output register:
- In the immediate mode, the word is latched on the clock edge where busy returns high.
- In the deferred mode, the word is parked until the next accepted convert-start edge, so a read always returns the sample before the latest one.

The host reads through chip-select and read. It writes the offset through chip-select and a write strobe, and the register takes the value on the falling edge of that strobe. The tri-state bus is split into separate data-out, data-out-enable and data-in ports. An asynchronous active-low reset aborts any conversion and clears all state.

All control inputs are assumed to be synchronous to `clk`. Edges on them are found by comparing each input with its value at the previous clock edge.

Top module: `sar_bus_ctrl`

## Requirements
- R1: While reset is held and right after its release, `busy_n` is 1, `dout` is 0, `conv_err` and `mode_err` are 0 and the offset is 0.
- R2: The clock edge that first samples `cnvst_n` low after it was high drives `busy_n` low. `busy_n` then stays low for exactly `CONV_CYCLES` clock cycles before it returns high.
- R3: The output word is the 14-bit `conv_result` plus the 14-bit offset, taken as a 15-bit unsigned sum. Bit 14 is the carry, which serves as the overrange bit.
- R4: When `mode_sel` = 2'b01, `dout` takes the new word on the same clock edge where `busy_n` returns high.
- R5: When `mode_sel` = 2'b10, `dout` is left unchanged at the end of a conversion. The word is held pending and moves to `dout` on the clock edge that accepts the next convert-start.
- R6: The reserved codes `mode_sel` = 2'b00 and 2'b11 behave as 2'b01. While such a code is applied, `mode_err` reads 1, starting one clock edge later.
- R7: `dout_en` is 1 exactly when `cs_n` and `rd_n` are both 0.
- R8: The offset takes `din[13:0]` on the clock edge that samples `wr` low after it was high, but only if `cs_n` is 0 at that edge. With `cs_n` at 1, the strobe leaves the offset unchanged.
- R9: A convert-start falling edge that arrives while `busy_n` is 0 does not restart or extend the conversion. It sets `conv_err`, which stays 1 until reset.
- R10: Asserting `rst_n` low aborts a conversion in progress without waiting for a clock: `busy_n` returns to 1, and the offset, the pending word, `dout` and `conv_err` are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cnvst_n | input | 1 | Convert start; its falling edge starts a conversion |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr | input | 1 | Write strobe; its falling edge loads the offset |
| mode_sel | input | 2 | Latching mode: 01 immediate, 10 deferred, 00/11 reserved |
| din | input | 15 | Data bus input; bits 13:0 carry the offset |
| conv_result | input | 14 | Modelled converter answer, sampled at end of conversion |
| dout | output | 15 | Output register contents |
| dout_en | output | 1 | Drive enable for the data bus |
| busy_n | output | 1 | Conversion in progress, active low |
| conv_err | output | 1 | Sticky flag: a start arrived while busy |
| mode_err | output | 1 | A reserved mode code is applied |

## Verification
The bench drives inputs on the falling clock edge. A start lowered at one falling edge makes `busy_n` read low at the next falling edge. `busy_n` reads high again `CONV_CYCLES` falling edges after that, and the immediate-mode word appears in that same sample. A deferred-mode word appears in the sample one falling edge after the start that releases it. Offset writes take effect from the falling edge after the strobe is lowered, and `mode_err` follows the mode pins one edge late. `dout_en` and the effects of reset are combinational, so they are sampled 1 ns after the stimulus. Each check is placed at the instant derived this way and compared against a model in the bench that tracks the offset, the pending word and the output register.

// File: rtl/sar_bus_pkg.sv
package sar_bus_pkg;

  typedef enum logic [0:0] {
    LATCH_AT_DONE = 1'b0,
    LATCH_AT_NEXT = 1'b1
  } latch_mode_e;

  // Only 2'b10 selects deferred latching; every other code latches at done.
  function automatic latch_mode_e decode_mode(input logic [1:0] sel);
    return (sel == 2'b10) ? LATCH_AT_NEXT : LATCH_AT_DONE;
  endfunction

  function automatic logic mode_is_reserved(input logic [1:0] sel);
    return (sel == 2'b00) || (sel == 2'b11);
  endfunction

endpackage

// File: rtl/sar_edge_det.sv
module sar_edge_det #(
  parameter logic IDLE_LEVEL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sig,
  output logic fall
);

  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= IDLE_LEVEL;
    else        prev_q <= sig;
  end

  assign fall = prev_q & ~sig;

endmodule

// File: rtl/sar_conv_timer.sv
module sar_conv_timer #(
  parameter int CONV_CYCLES = 30
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_req,
  output logic busy,
  output logic start_ok,
  output logic done
);

  localparam int CNT_W = (CONV_CYCLES > 1) ? $clog2(CONV_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CONV_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;

  assign start_ok = start_req & ~busy_q;
  assign done     = busy_q & (cnt_q == '0);
  assign busy     = busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_ok) begin
      busy_q <= 1'b1;
      cnt_q  <= LAST;
    end else if (done) begin
      busy_q <= 1'b0;
    end else if (busy_q) begin
      cnt_q  <= cnt_q - 1'b1;
    end
  end

endmodule

// File: rtl/sar_out_latch.sv
module sar_out_latch
  import sar_bus_pkg::*;
#(
  parameter int RES_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             done,
  input  logic             start_ok,
  input  latch_mode_e      mode,
  input  logic [RES_W-1:0] result,
  input  logic [RES_W-1:0] offset,
  output logic [RES_W:0]   word_q
);

  logic [RES_W:0] pend_q;
  logic [RES_W:0] sum;

  function automatic logic [RES_W:0] add_offset(input logic [RES_W-1:0] r,
                                                input logic [RES_W-1:0] o);
    return {1'b0, r} + {1'b0, o};
  endfunction

  assign sum = add_offset(result, offset);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      pend_q <= '0;
    end else begin
      if (done && mode == LATCH_AT_DONE) word_q <= sum;
      if (done && mode == LATCH_AT_NEXT) pend_q <= sum;
      if (start_ok && mode == LATCH_AT_NEXT) word_q <= pend_q;
    end
  end

endmodule

// File: rtl/sar_bus_ctrl.sv
module sar_bus_ctrl
  import sar_bus_pkg::*;
#(
  parameter int RES_W       = 14,
  parameter int CONV_CYCLES = 30
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnvst_n,
  input  logic             cs_n,
  input  logic             rd_n,
  input  logic             wr,
  input  logic [1:0]       mode_sel,
  input  logic [RES_W:0]   din,
  input  logic [RES_W-1:0] conv_result,
  output logic [RES_W:0]   dout,
  output logic             dout_en,
  output logic             busy_n,
  output logic             conv_err,
  output logic             mode_err
);

  logic             cnvst_fall;
  logic             wr_fall;
  logic             busy;
  logic             conv_start;
  logic             conv_done;
  logic             offset_load;
  logic [RES_W-1:0] offset_q;
  latch_mode_e      mode;

  sar_edge_det #(.IDLE_LEVEL(1'b1)) u_cnvst_edge (
    .clk(clk), .rst_n(rst_n), .sig(cnvst_n), .fall(cnvst_fall)
  );

  sar_edge_det #(.IDLE_LEVEL(1'b0)) u_wr_edge (
    .clk(clk), .rst_n(rst_n), .sig(wr), .fall(wr_fall)
  );

  sar_conv_timer #(.CONV_CYCLES(CONV_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start_req(cnvst_fall),
    .busy(busy), .start_ok(conv_start), .done(conv_done)
  );

  assign mode = decode_mode(mode_sel);

  sar_out_latch #(.RES_W(RES_W)) u_latch (
    .clk(clk), .rst_n(rst_n), .done(conv_done), .start_ok(conv_start),
    .mode(mode), .result(conv_result), .offset(offset_q), .word_q(dout)
  );

  assign offset_load = wr_fall & ~cs_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      offset_q <= '0;
      conv_err <= 1'b0;
      mode_err <= 1'b0;
    end else begin
      if (offset_load) offset_q <= din[RES_W-1:0];
      if (cnvst_fall && busy) conv_err <= 1'b1;
      mode_err <= mode_is_reserved(mode_sel);
    end
  end

  assign busy_n  = ~busy;
  assign dout_en = ~cs_n & ~rd_n;

endmodule

// File: rtl/sar_bus_chk.sv
module sar_bus_chk #(
  parameter int RES_W       = 14,
  parameter int CONV_CYCLES = 30
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy_n,
  input logic             conv_start,
  input logic             conv_done,
  input logic             conv_err,
  input logic [1:0]       mode_sel,
  input logic [RES_W-1:0] conv_result,
  input logic [RES_W-1:0] offset_q,
  input logic [RES_W:0]   dout
);

  localparam int CW = $clog2(CONV_CYCLES + 2);
  logic [CW-1:0] low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       low_cnt <= '0;
    else if (!busy_n) low_cnt <= low_cnt + 1'b1;
    else              low_cnt <= '0;
  end

  // R2
  start_drops_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !busy_n);

  // R2
  busy_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_n) |-> (low_cnt == CW'(CONV_CYCLES)));

  // R9
  no_start_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> busy_n);

  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_err |=> conv_err);

  // R4
  immediate_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && mode_sel != 2'b10) |=>
      (dout == ({1'b0, $past(conv_result)} + {1'b0, $past(offset_q)})));

  // R5
  deferred_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && mode_sel == 2'b10) |=> $stable(dout));

endmodule

bind sar_bus_ctrl sar_bus_chk #(.RES_W(RES_W), .CONV_CYCLES(CONV_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy_n(busy_n), .conv_start(conv_start),
  .conv_done(conv_done), .conv_err(conv_err), .mode_sel(mode_sel),
  .conv_result(conv_result), .offset_q(offset_q), .dout(dout)
);

// File: tb/tb_sar_bus_ctrl.sv
`timescale 1ns/1ps
module tb_sar_bus_ctrl;

  localparam int RES_W = 14;
  localparam int CONV  = 30;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cnvst_n = 1'b1, cs_n = 1'b1, rd_n = 1'b1, wr = 1'b0;
  logic [1:0]       mode_sel = 2'b01;
  logic [RES_W:0]   din = '0;
  logic [RES_W-1:0] conv_result = '0;
  logic [RES_W:0]   dout;
  logic             dout_en, busy_n, conv_err, mode_err;

  int checks = 0, errors = 0;
  logic [RES_W-1:0] m_off = '0;
  logic [RES_W:0]   m_pend = '0, m_out = '0;
  logic             m_err = 1'b0;
  bit               done_flag = 0;

  sar_bus_ctrl #(.RES_W(RES_W), .CONV_CYCLES(CONV)) dut (
    .clk(clk), .rst_n(rst_n), .cnvst_n(cnvst_n), .cs_n(cs_n), .rd_n(rd_n),
    .wr(wr), .mode_sel(mode_sel), .din(din), .conv_result(conv_result),
    .dout(dout), .dout_en(dout_en), .busy_n(busy_n), .conv_err(conv_err),
    .mode_err(mode_err)
  );

  always #5 clk = ~clk;

  function automatic logic [RES_W:0] exp_word(input logic [RES_W-1:0] r,
                                              input logic [RES_W-1:0] o);
    int unsigned s;
    s = int'(r) + int'(o);
    return s[RES_W:0];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    finish_run();
  end

  task automatic write_offset(input logic [RES_W:0] v, input logic sel);
    @(negedge clk); cs_n = ~sel; din = v; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
    @(negedge clk); cs_n = 1'b1;
    if (sel) m_off = v[RES_W-1:0];
  endtask

  task automatic read_check(input string req);
    @(negedge clk); cs_n = 1'b0; rd_n = 1'b0; #1;
    check({req, " R7 en"}, 32'(dout_en), 32'd1);
    check(req, 32'(dout), 32'(m_out));
    rd_n = 1'b1; #1;
    check("R7 rd high", 32'(dout_en), 32'd0);
    cs_n = 1'b1;
  endtask

  // One full conversion; mode and result applied before the start edge.
  task automatic convert(input logic [1:0] m, input logic [RES_W-1:0] r);
    int low_seen;
    @(negedge clk); mode_sel = m; conv_result = r;
    @(negedge clk);
    check("R6 mode_err", 32'(mode_err), 32'((m == 2'b00) || (m == 2'b11)));
    cnvst_n = 1'b0;
    @(negedge clk); cnvst_n = 1'b1;
    if (m == 2'b10) m_out = m_pend;
    check("R5 load at start", 32'(dout), 32'(m_out));
    low_seen = busy_n ? 0 : 1;
    for (int i = 2; i <= CONV; i++) begin
      @(negedge clk);
      if (!busy_n) low_seen++;
    end
    check("R2 busy low cycles", 32'(low_seen), 32'(CONV));
    @(negedge clk);
    check("R2 busy released", 32'(busy_n), 32'd1);
    if (m == 2'b10) m_pend = exp_word(r, m_off);
    else            m_out  = exp_word(r, m_off);
    check((m == 2'b10) ? "R5 hold at done" : "R4 R3 word at done", 32'(dout), 32'(m_out));
  endtask

  initial begin
    void'($urandom(32'h5A17));
    #1;
    check("R1 busy in reset", 32'(busy_n), 32'd1);
    check("R1 dout in reset", 32'(dout), 32'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 errs", 32'({conv_err, mode_err}), 32'd0);
    check("R7 idle en", 32'(dout_en), 32'd0);
    cs_n = 1'b0; #1;
    check("R7 cs only", 32'(dout_en), 32'd0);
    cs_n = 1'b1; rd_n = 1'b0; #1;
    check("R7 rd only", 32'(dout_en), 32'd0);
    rd_n = 1'b1;

    // R1 offset zero: result passes unchanged
    convert(2'b01, 14'h1234);
    read_check("R1 R4 zero offset");

    // R3 carry into bit 14
    write_offset(15'h3000, 1'b1);
    convert(2'b01, 14'h3FFF);
    check("R3 carry", 32'(dout[RES_W]), 32'd1);
    // R8 write ignored without chip select
    write_offset(15'h0005, 1'b0);
    convert(2'b01, 14'h0010);
    read_check("R8 ignored write");

    // R5 deferred mode across two samples
    write_offset(15'h0001, 1'b1);
    convert(2'b10, 14'h0100);
    convert(2'b10, 14'h0200);
    read_check("R5 previous sample");

    // R6 reserved codes
    convert(2'b00, 14'h0ABC);
    convert(2'b11, 14'h0DEF);
    read_check("R6 reserved as immediate");

    // R9 start while busy
    @(negedge clk); mode_sel = 2'b01; conv_result = 14'h0777;
    cnvst_n = 1'b0;
    @(negedge clk); cnvst_n = 1'b1;
    repeat (5) @(negedge clk);
    cnvst_n = 1'b0;
    @(negedge clk); cnvst_n = 1'b1;
    check("R9 err set", 32'(conv_err), 32'd1);
    repeat (CONV - 7) @(negedge clk);
    check("R9 still busy", 32'(busy_n), 32'd0);
    @(negedge clk);
    check("R9 not extended", 32'(busy_n), 32'd1);
    m_out = exp_word(14'h0777, m_off);
    check("R9 word", 32'(dout), 32'(m_out));
    repeat (4) @(negedge clk);
    check("R9 sticky", 32'(conv_err), 32'd1);

    // R10 reset aborts mid conversion
    @(negedge clk); cnvst_n = 1'b0;
    @(negedge clk); cnvst_n = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b0; #1;
    check("R10 busy cleared", 32'(busy_n), 32'd1);
    check("R10 dout cleared", 32'(dout), 32'd0);
    check("R10 err cleared", 32'(conv_err), 32'd0);
    m_off = '0; m_pend = '0; m_out = '0;
    @(negedge clk); rst_n = 1'b1;
    convert(2'b10, 14'h0042);
    check("R10 pending cleared", 32'(dout), 32'd0);
    convert(2'b01, 14'h0042);
    check("R10 offset cleared", 32'(dout), 32'h0042);

    // Random mix
    for (int n = 0; n < 40; n++) begin
      if ($urandom_range(3) == 0)
        write_offset(15'($urandom), ($urandom_range(1) == 1));
      convert(2'($urandom), 14'($urandom));
      if ($urandom_range(1) == 1) read_check("R3 random read");
    end

    finish_run();
  end

endmodule